// File: doc/BRIEF.md
# SGRAM Power-Up Initialization Sequencer

This block sits on the controller side of a synchronous graphics DRAM and takes the memory from power-on to a usable state. After reset it keeps clock enable and the data mask high and leaves the command bus idle. The idle stretch is the stable-power interval, sized in clock cycles from a clock-rate parameter and a microsecond parameter. When that interval ends, the block walks through a fixed list of commands: a precharge of all banks, a parameterized number of auto-refreshes, a mode register load and a special mode register load. After each command it leaves a parameterized number of idle cycles before the next one.

The mode word is built from configuration inputs: CAS latency, burst type, burst length and write-burst mode. The special mode word carries the load-color enable. If a configuration asks for a reserved latency, or for a burst length that the chosen burst type does not allow, the block flags the error and loads a safe default instead. One configuration bit decides whether the refreshes come before the two mode loads or after them. When the last command's wait has elapsed, the ready flag rises and stays high until the next reset.

Top module: `sgram_init_seq`

## Requirements
- R1: While reset is asserted and during the stable-power wait, cke=1, dqm=1, ready=0 and the command pins {cs_n,ras_n,cas_n,we_n} read 4'b0111 (no operation).
- R2: The wait lasts P = CLK_MHZ*POWERUP_US cycles. Counting the rising edges after reset is released as cycles 1, 2, …, precharge-all appears at cycle P as pins 4'b0010 with addr[10]=1 and every other address bit 0.
- R3: With cfg_mrs_first=0 the order is: precharge, then NUM_REFRESH auto-refreshes (pins 4'b0001, address 0), then the mode load, then the special mode load.
- R4: With cfg_mrs_first=1 the order is: precharge, then the mode load, then the special mode load, then NUM_REFRESH auto-refreshes.
- R5: Each command lasts one cycle. It is followed by exactly TRP idle cycles after a precharge, TRC after a refresh, and TMRD after either mode load.
- R6: The mode load drives pins 4'b0000 with spec_sel=0, ba=0 and this address: [2:0] burst length code, [3] burst type (1 = interleave), [6:4] CAS latency code, [8:7] = 00, [9] = write single-bit, [10] = 0.
- R7: The special mode load drives pins 4'b0000 with spec_sel=1 and ba=0. Its address has bit 6 = load-color enable and every other bit 0.
- R8: cfg_err is high, combinationally, exactly when the configuration is reserved. Legal latency codes are 010 and 011. Legal length codes are 000, 001, 010, 011 and 111 with sequential burst, and 010 and 011 with interleave.
- R9: For a reserved configuration, mode-word bits [6:0] are 7'b0100000 (latency 2, sequential, length 1), and bit 9 still follows the write-burst input.
- R10: ready rises in the cycle right after the last command's idle gap ends. It stays high until reset, with dqm=0 and no further commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cas_lat | input | 3 | CAS latency code |
| cfg_burst_il | input | 1 | Burst type, 1 = interleave |
| cfg_burst_len | input | 3 | Burst length code |
| cfg_wr_single | input | 1 | Write-burst mode, 1 = single-bit writes |
| cfg_load_color | input | 1 | Load-color enable for the special mode word |
| cfg_mrs_first | input | 1 | 1 = mode loads before refreshes |
| cke | output | 1 | Clock enable |
| dqm | output | 1 | Data mask, high until ready |
| cs_n | output | 1 | Chip select |
| ras_n | output | 1 | Row strobe |
| cas_n | output | 1 | Column strobe |
| we_n | output | 1 | Write enable |
| spec_sel | output | 1 | Marks a mode load as the special mode load |
| addr | output | ADDR_W | Address bus |
| ba | output | BA_W | Bank address |
| ready | output | 1 | Initialization complete |
| cfg_err | output | 1 | Configuration uses a reserved code |

## Verification
The sequence is run in both orders. The two orders interleave the refresh gaps and the mode-load gaps differently, so a wrong gap or a wrong step index moves the issue cycle of every later command. The configurations tested are a legal sequential burst, a legal interleaved burst, a full-page sequential burst, a reserved latency and a full-page interleaved burst. Together they separate the packing of each field from the substitution of the default. A sweep over every latency, type and length code compares the error flag against the legality rule, so an extra code or a missing code in the legal set shows up.

// File: rtl/sgram_init_pkg.sv
package sgram_init_pkg;

   // {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_MODE  = 4'b0000,
      CMD_REF   = 4'b0001,
      CMD_PRE   = 4'b0010,
      CMD_IDLE  = 4'b0111
   } cmd_e;

   typedef enum logic [1:0] {
      STEP_PRE,
      STEP_REF,
      STEP_MODE,
      STEP_SPEC
   } step_e;

   typedef enum logic [1:0] {
      ST_POWER,
      ST_ISSUE,
      ST_GAP,
      ST_READY
   } state_e;

   typedef struct packed {
      logic [2:0] cas_lat;
      logic       burst_il;
      logic [2:0] burst_len;
      logic       wr_single;
      logic       load_color;
   } mode_cfg_t;

endpackage

// File: rtl/sgram_mode_word.sv
module sgram_mode_word
   import sgram_init_pkg::*;
(
   input  mode_cfg_t   cfg,
   output logic [10:0] mode_word,
   output logic [10:0] spec_word,
   output logic        cfg_err
);

   logic       cas_ok;
   logic       len_ok;
   logic [2:0] cas_eff;
   logic       il_eff;
   logic [2:0] len_eff;

   always_comb begin
      cas_ok = (cfg.cas_lat == 3'b010) || (cfg.cas_lat == 3'b011);
      if (cfg.burst_il)
         len_ok = (cfg.burst_len == 3'b010) || (cfg.burst_len == 3'b011);
      else
         len_ok = !cfg.burst_len[2] || (cfg.burst_len == 3'b111);
      cfg_err = !(cas_ok && len_ok);
      cas_eff = cfg_err ? 3'b010 : cfg.cas_lat;
      il_eff  = cfg_err ? 1'b0   : cfg.burst_il;
      len_eff = cfg_err ? 3'b000 : cfg.burst_len;
   end

   assign mode_word = {1'b0, cfg.wr_single, 2'b00, cas_eff, il_eff, len_eff};
   assign spec_word = {4'b0000, cfg.load_color, 6'b000000};

endmodule

// File: rtl/sgram_step_table.sv
module sgram_step_table
   import sgram_init_pkg::*;
#(
   parameter int NUM_REFRESH = 2,
   parameter int NSTEP       = NUM_REFRESH + 3,
   parameter int SW          = $clog2(NSTEP)
) (
   input  logic [SW-1:0] idx,
   input  logic          mrs_first,
   output step_e         kind,
   output logic          last
);

   step_e tbl_rf [NSTEP];
   step_e tbl_mf [NSTEP];

   for (genvar k = 0; k < NSTEP; k++) begin : g_step
      if (k == 0) begin : g_head
         assign tbl_rf[k] = STEP_PRE;
         assign tbl_mf[k] = STEP_PRE;
      end else begin : g_body
         assign tbl_rf[k] = (k <= NUM_REFRESH)     ? STEP_REF  :
                            (k == NUM_REFRESH + 1) ? STEP_MODE : STEP_SPEC;
         assign tbl_mf[k] = (k == 1) ? STEP_MODE :
                            (k == 2) ? STEP_SPEC : STEP_REF;
      end
   end

   assign kind = mrs_first ? tbl_mf[idx] : tbl_rf[idx];
   assign last = (idx == SW'(NSTEP - 1));

endmodule

// File: rtl/sgram_gap_timer.sv
module sgram_gap_timer #(
   parameter int CW      = 8,
   parameter int RST_VAL = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          zero
);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= CW'(RST_VAL);
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/sgram_init_seq.sv
module sgram_init_seq
   import sgram_init_pkg::*;
#(
   parameter int CLK_MHZ     = 125,
   parameter int POWERUP_US  = 200,
   parameter int NUM_REFRESH = 2,
   parameter int TRP         = 3,
   parameter int TRC         = 9,
   parameter int TMRD        = 2,
   parameter int ADDR_W      = 11,
   parameter int BA_W        = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        cfg_cas_lat,
   input  logic              cfg_burst_il,
   input  logic [2:0]        cfg_burst_len,
   input  logic              cfg_wr_single,
   input  logic              cfg_load_color,
   input  logic              cfg_mrs_first,
   output logic              cke,
   output logic              dqm,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic              spec_sel,
   output logic [ADDR_W-1:0] addr,
   output logic [BA_W-1:0]   ba,
   output logic              ready,
   output logic              cfg_err
);

   localparam int P_CYC = CLK_MHZ * POWERUP_US;
   localparam int NSTEP = NUM_REFRESH + 3;
   localparam int SW    = $clog2(NSTEP);
   localparam int MAXG  = (TRP > TRC) ? ((TRP > TMRD) ? TRP : TMRD)
                                      : ((TRC > TMRD) ? TRC : TMRD);
   localparam int MAXV  = (P_CYC > MAXG) ? P_CYC : MAXG;
   localparam int CW    = $clog2(MAXV + 1);

   initial begin
      assert (NUM_REFRESH >= 2) else $error("NUM_REFRESH must be at least 2");
      assert (TRP >= 1 && TRC >= 1 && TMRD >= 1) else $error("gaps must be >= 1");
      assert (P_CYC >= 1) else $error("power-up wait must be >= 1 cycle");
      assert (ADDR_W >= 11) else $error("ADDR_W must be at least 11");
      assert (BA_W >= 1) else $error("BA_W must be at least 1");
   end

   mode_cfg_t   cfg;
   logic [10:0] mode_word;
   logic [10:0] spec_word;
   state_e      st;
   logic [SW-1:0] step_idx;
   step_e       kind;
   logic        step_last;
   logic        t_zero;
   logic        t_load;
   logic [CW-1:0] t_val;
   cmd_e        cmd;

   assign cfg = '{cas_lat: cfg_cas_lat, burst_il: cfg_burst_il,
                  burst_len: cfg_burst_len, wr_single: cfg_wr_single,
                  load_color: cfg_load_color};

   sgram_mode_word u_word (
      .cfg      (cfg),
      .mode_word(mode_word),
      .spec_word(spec_word),
      .cfg_err  (cfg_err)
   );

   sgram_step_table #(
      .NUM_REFRESH(NUM_REFRESH),
      .NSTEP      (NSTEP),
      .SW         (SW)
   ) u_steps (
      .idx      (step_idx),
      .mrs_first(cfg_mrs_first),
      .kind     (kind),
      .last     (step_last)
   );

   always_comb begin
      case (kind)
         STEP_PRE: t_val = CW'(TRP - 1);
         STEP_REF: t_val = CW'(TRC - 1);
         default:  t_val = CW'(TMRD - 1);
      endcase
   end
   assign t_load = (st == ST_ISSUE);

   sgram_gap_timer #(
      .CW     (CW),
      .RST_VAL(P_CYC - 1)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (t_load),
      .load_val(t_val),
      .zero    (t_zero)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_POWER;
         step_idx <= '0;
      end else begin
         case (st)
            ST_POWER: if (t_zero) st <= ST_ISSUE;
            ST_ISSUE: st <= ST_GAP;
            ST_GAP: begin
               if (t_zero) begin
                  if (step_last) begin
                     st <= ST_READY;
                  end else begin
                     st       <= ST_ISSUE;
                     step_idx <= step_idx + 1'b1;
                  end
               end
            end
            default: st <= ST_READY;
         endcase
      end
   end

   always_comb begin
      cmd      = CMD_IDLE;
      addr     = '0;
      spec_sel = 1'b0;
      if (st == ST_ISSUE) begin
         case (kind)
            STEP_PRE: begin
               cmd      = CMD_PRE;
               addr[10] = 1'b1;
            end
            STEP_REF: cmd = CMD_REF;
            STEP_MODE: begin
               cmd        = CMD_MODE;
               addr[10:0] = mode_word;
            end
            default: begin
               cmd        = CMD_MODE;
               addr[10:0] = spec_word;
               spec_sel   = 1'b1;
            end
         endcase
      end
   end

   assign {cs_n, ras_n, cas_n, we_n} = cmd;
   assign ba    = '0;
   assign cke   = 1'b1;
   assign ready = (st == ST_READY);
   assign dqm   = !ready;

   a_r1_idle_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_POWER) |-> ({cs_n, ras_n, cas_n, we_n} == 4'b0111 && cke && dqm && !ready));

   a_r5_one_cycle_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      ({cs_n, ras_n, cas_n, we_n} != 4'b0111) |=> ({cs_n, ras_n, cas_n, we_n} == 4'b0111));

   a_r6_mode_reserved_low: assert property (@(posedge clk) disable iff (!rst_n)
      ({cs_n, ras_n, cas_n, we_n} == 4'b0000 && !spec_sel) |-> (addr[10] == 1'b0 && addr[8:7] == 2'b00));

   a_r7_spec_word: assert property (@(posedge clk) disable iff (!rst_n)
      ({cs_n, ras_n, cas_n, we_n} == 4'b0000 && spec_sel)
         |-> (addr[6] == cfg_load_color && $countones(addr) <= 1));

   a_r9_safe_default: assert property (@(posedge clk) disable iff (!rst_n)
      ({cs_n, ras_n, cas_n, we_n} == 4'b0000 && !spec_sel && cfg_err) |-> (addr[6:0] == 7'b0100000));

   a_r10_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> ready);

   a_r10_quiet_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> ({cs_n, ras_n, cas_n, we_n} == 4'b0111 && !dqm));

endmodule

// File: tb/sgram_init_seq_tb.sv
`timescale 1ns/1ps
module sgram_init_seq_tb;

   localparam int CLK_MHZ    = 125;
   localparam int POWERUP_US = 2;
   localparam int NREF       = 3;
   localparam int TRP        = 2;
   localparam int TRC        = 4;
   localparam int TMRD       = 1;
   localparam int P          = CLK_MHZ * POWERUP_US;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  cfg_cas_lat = 3'b010;
   logic        cfg_burst_il = 1'b0;
   logic [2:0]  cfg_burst_len = 3'b000;
   logic        cfg_wr_single = 1'b0;
   logic        cfg_load_color = 1'b0;
   logic        cfg_mrs_first = 1'b0;
   logic        cke, dqm, cs_n, ras_n, cas_n, we_n, spec_sel, ready, cfg_err;
   logic [10:0] addr;
   logic [0:0]  ba;

   always #4 clk = ~clk;

   sgram_init_seq #(
      .CLK_MHZ(CLK_MHZ), .POWERUP_US(POWERUP_US), .NUM_REFRESH(NREF),
      .TRP(TRP), .TRC(TRC), .TMRD(TMRD), .ADDR_W(11), .BA_W(1)
   ) u_dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_cas_lat(cfg_cas_lat), .cfg_burst_il(cfg_burst_il),
      .cfg_burst_len(cfg_burst_len), .cfg_wr_single(cfg_wr_single),
      .cfg_load_color(cfg_load_color), .cfg_mrs_first(cfg_mrs_first),
      .cke(cke), .dqm(dqm), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .spec_sel(spec_sel), .addr(addr), .ba(ba), .ready(ready), .cfg_err(cfg_err)
   );

   typedef struct {
      int          cyc;
      logic [3:0]  pins;
      logic [10:0] addr;
      logic        spec;
      string       tag;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   errors = 0;
   int   cyc = 0;
   int   exp_ready = 0;
   bit   ready_seen = 0;
   bit   active = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   function automatic bit exp_err(input logic [2:0] cas, input logic il, input logic [2:0] bl);
      bit cas_ok = (cas == 3'd2) || (cas == 3'd3);
      bit bl_ok  = il ? ((bl == 3'd2) || (bl == 3'd3)) : ((bl <= 3'd3) || (bl == 3'd7));
      return !(cas_ok && bl_ok);
   endfunction

   function automatic logic [10:0] exp_mode(input logic [2:0] cas, input logic il,
                                            input logic [2:0] bl, input logic ws);
      logic [10:0] w = '0;
      w[9] = ws;
      if (exp_err(cas, il, bl)) begin
         w[6:4] = 3'd2;
      end else begin
         w[6:4] = cas;
         w[3]   = il;
         w[2:0] = bl;
      end
      return w;
   endfunction

   task automatic push(input int c, input logic [3:0] pins, input logic [10:0] a,
                       input logic spec, input string tag);
      exp_t e;
      e.cyc = c; e.pins = pins; e.addr = a; e.spec = spec; e.tag = tag;
      q.push_back(e);
   endtask

   // monitor / scoreboard
   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   always @(negedge clk) begin
      if (rst_n && active) begin
         logic [3:0] pins;
         pins = {cs_n, ras_n, cas_n, we_n};
         if (!ready_seen && ready) begin
            ready_seen = 1;
            chk(cyc == exp_ready, "R10", "ready rise cycle", cyc, exp_ready);
         end
         if (ready)
            chk(dqm == 1'b0 && pins == 4'b0111, "R10", "quiet after ready {dqm,pins}",
                {dqm, pins}, 5'b00111);
         else if (cyc < P)
            chk(pins == 4'b0111 && dqm && cke && !ready, "R1", "wait {cke,dqm,ready,pins}",
                {cke, dqm, ready, pins}, 7'b1100111);
         if (pins != 4'b0111) begin
            if (q.size() == 0) begin
               chk(1'b0, "R3", "unexpected command pins", pins, 4'b0111);
            end else begin
               exp_t e;
               e = q.pop_front();
               chk(cyc == e.cyc, "R5", {e.tag, " issue cycle"}, cyc, e.cyc);
               chk(pins == e.pins, e.tag, "command pins", pins, e.pins);
               chk(addr == e.addr && ba == 1'b0, e.tag, "address", {ba, addr}, {1'b0, e.addr});
               chk(spec_sel == e.spec, e.tag, "spec_sel", spec_sel, e.spec);
            end
         end
      end
   end

   task automatic run_case(input bit mf, input logic [2:0] cas, input logic il,
                           input logic [2:0] bl, input logic ws, input logic lc);
      int t;
      logic [10:0] mw;
      @(posedge clk); #1;
      rst_n = 1'b0;
      active = 1'b0;
      cfg_mrs_first = mf; cfg_cas_lat = cas; cfg_burst_il = il;
      cfg_burst_len = bl; cfg_wr_single = ws; cfg_load_color = lc;
      repeat (3) @(posedge clk);
      #2;
      chk({cke, dqm, ready, cs_n, ras_n, cas_n, we_n} == 7'b1100111, "R1", "reset state",
          {cke, dqm, ready, cs_n, ras_n, cas_n, we_n}, 7'b1100111);
      chk(cfg_err == exp_err(cas, il, bl), "R8", "cfg_err for run", cfg_err, exp_err(cas, il, bl));
      mw = exp_mode(cas, il, bl, ws);
      q.delete();
      t = P;
      push(t, 4'b0010, 11'h400, 1'b0, "R2"); t += TRP + 1;
      if (!mf) begin
         for (int i = 0; i < NREF; i++) begin push(t, 4'b0001, 11'h000, 1'b0, "R3"); t += TRC + 1; end
         push(t, 4'b0000, mw, 1'b0, (exp_err(cas, il, bl) ? "R9" : "R6")); t += TMRD + 1;
         push(t, 4'b0000, {4'b0, lc, 6'b0}, 1'b1, "R7"); t += TMRD + 1;
      end else begin
         push(t, 4'b0000, mw, 1'b0, (exp_err(cas, il, bl) ? "R9" : "R6")); t += TMRD + 1;
         push(t, 4'b0000, {4'b0, lc, 6'b0}, 1'b1, "R7"); t += TMRD + 1;
         for (int i = 0; i < NREF; i++) begin push(t, 4'b0001, 11'h000, 1'b0, "R4"); t += TRC + 1; end
      end
      exp_ready = t;
      ready_seen = 1'b0;
      active = 1'b1;
      @(posedge clk); #1;
      rst_n = 1'b1;
      for (int i = 0; i < P + 400; i++) begin
         @(posedge clk);
         if (ready_seen) break;
      end
      repeat (20) @(posedge clk);
      chk(ready_seen, "R10", "ready reached", ready_seen, 1);
      chk(q.size() == 0, mf ? "R4" : "R3", "commands left unissued", q.size(), 0);
      #1;
      active = 1'b0;
      rst_n = 1'b0;
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL R10 watchdog expired act=running exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (2) @(posedge clk);
      #1;
      // R8: legality sweep over every code, held in reset
      for (int c = 0; c < 8; c++) begin
         for (int b = 0; b < 2; b++) begin
            for (int l = 0; l < 8; l++) begin
               cfg_cas_lat = 3'(c); cfg_burst_il = 1'(b); cfg_burst_len = 3'(l);
               #1;
               chk(cfg_err == exp_err(3'(c), 1'(b), 3'(l)), "R8", "cfg_err sweep",
                   cfg_err, exp_err(3'(c), 1'(b), 3'(l)));
            end
         end
      end
      run_case(1'b0, 3'b011, 1'b0, 3'b011, 1'b0, 1'b1); // R3 R6 legal sequential
      run_case(1'b1, 3'b010, 1'b1, 3'b010, 1'b1, 1'b0); // R4 R6 interleave
      run_case(1'b0, 3'b100, 1'b0, 3'b001, 1'b1, 1'b1); // R9 reserved latency
      run_case(1'b1, 3'b011, 1'b1, 3'b111, 1'b0, 1'b1); // R9 full page with interleave
      run_case(1'b0, 3'b010, 1'b0, 3'b111, 1'b0, 1'b0); // R6 full page sequential
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule